// File: doc/BRIEF.md
# Streaming Linearity Accumulator

This block sits behind a sliding code-count window used to test an A/D converter with a slow ramp. Each time the window moves on, one finished code count arrives with a one-cycle valid strobe. The block turns that count into a per-code differential nonlinearity figure. The figure is the count minus a programmed ideal count, in signed fixed point where one unit is 1/8 LSB.

The block adds each per-code figure into a running integral nonlinearity value. It keeps the largest magnitude of each figure seen since reset. Four sticky flags are kept:

- a DNL range overflow flag;
- an INL range overflow flag;
- a missing-code flag for a zero count;
- a fail flag.

The fail verdict is raised when a peak goes above its programmed threshold, or when either overflow flag is set. A test sequence is started by pulsing the synchronous reset. After the last code, the verdict is read from the outputs.

Top module: `linearity_accum`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output register clears: per-code values 0, peaks 0, all flags 0, `fail_o` 0 and `pass_o` 1.
- R2: On the clock edge where `cnt_valid_i` is high, `dnl_o` takes the value `cnt_i - ideal_i`. It is held as 4-bit two's complement in 1/8 LSB units and is visible after that edge. With `cnt_valid_i` low, `dnl_o` holds its value.
- R3: If `cnt_i - ideal_i` lies outside -8..+7 (that is, -1 LSB to +0.875 LSB), then `dnl_o` clamps to the nearer limit and `dnl_ovf_o` sets. The flag stays set until reset.
- R4: On each valid count, `inl_o` becomes the previous `inl_o` plus the new, clamped `dnl_o`. It is held as 6-bit two's complement. With no valid count, it holds its value.
- R5: If the running sum lies outside -32..+31 (that is, -4 LSB to +3.875 LSB), then `inl_o` clamps to the nearer limit and `inl_ovf_o` sets. The flag stays set until reset.
- R6: `dnl_peak_o` is the largest |`dnl_o`| since reset. It is updated only when a new magnitude is strictly larger, so it never decreases.
- R7: `inl_peak_o` is the largest |`inl_o`| since reset, with the same update rule as R6.
- R8: A valid count of zero sets `missing_o`, and the flag stays set until reset.
- R9: `fail_o` is high when `dnl_peak_o > dnl_thr_i` or `inl_peak_o > inl_thr_i`. A peak equal to its threshold does not fail. The usual thresholds are 4 (0.5 LSB) and 8 (1 LSB). `pass_o` is always the inverse of `fail_o`.
- R10: Either overflow flag forces `fail_o` high, whatever the peaks and thresholds are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, which also starts a new test |
| cnt_valid_i | input | 1 | One-cycle strobe for a completed code count |
| cnt_i | input | 5 | Completed code count |
| ideal_i | input | 5 | Ideal count per code |
| dnl_thr_i | input | 4 | DNL magnitude threshold, in 1/8 LSB |
| inl_thr_i | input | 6 | INL magnitude threshold, in 1/8 LSB |
| dnl_o | output | 4 | Per-code DNL, signed |
| inl_o | output | 6 | Running INL, signed |
| dnl_peak_o | output | 4 | Largest DNL magnitude |
| inl_peak_o | output | 6 | Largest INL magnitude |
| dnl_ovf_o | output | 1 | Sticky DNL range overflow |
| inl_ovf_o | output | 1 | Sticky INL range overflow |
| missing_o | output | 1 | Sticky missing-code flag |
| fail_o | output | 1 | Test verdict: fail |
| pass_o | output | 1 | Test verdict: pass |

## Verification
A wrong running INL register shows on `inl_o` on the same edge as the count that corrupted it. It keeps showing on later codes, because every later sum inherits the error. A peak register that misses an update, or that updates on a smaller value, differs from the model on the edge of that strobe. It can flip the verdict at the same moment. Lost clamping or a lost sticky flag shows on the edge of the offending count, and again on any strobe after it. For this reason the reference model is compared on every clock.

// File: rtl/lin_pkg.sv
// Package: shared types for the linearity accumulator.
// Assumes nothing beyond plain two-state flags.
package lin_pkg;
    typedef struct packed {
        logic dnl_ovf;
        logic inl_ovf;
        logic missing;
    } lin_flags_t;
endpackage

// File: rtl/lin_dnl_stage.sv
// Per-code DNL stage: subtracts the ideal count from a finished code count,
// clamps to the signed DNL field and keeps the sticky DNL-overflow and
// missing-code flags. Assumes CNT_W+1 > DNL_W so the raw difference can
// exceed the field in both directions.
module lin_dnl_stage #(
    parameter int CNT_W = 5,
    parameter int DNL_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_i,
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [CNT_W-1:0]        ideal_i,
    output logic signed [DNL_W-1:0] dnl_next_o,
    output logic signed [DNL_W-1:0] dnl_q_o,
    output logic                    ovf_q_o,
    output logic                    miss_q_o
);
    localparam int DIFF_W = CNT_W + 1;
    localparam logic signed [DIFF_W-1:0] DIFF_HI = DIFF_W'(2**(DNL_W-1) - 1);
    localparam logic signed [DIFF_W-1:0] DIFF_LO = -DIFF_W'(2**(DNL_W-1));
    localparam logic signed [DNL_W-1:0]  SAT_HI  = DNL_W'(2**(DNL_W-1) - 1);
    localparam logic signed [DNL_W-1:0]  SAT_LO  = {1'b1, {(DNL_W-1){1'b0}}};

    logic signed [DIFF_W-1:0] diff;
    logic                     out_of_range;

    // Raw difference, then clamp to the field limits.
    always_comb begin
        diff         = $signed({1'b0, cnt_i}) - $signed({1'b0, ideal_i});
        out_of_range = 1'b0;
        if (diff > DIFF_HI) begin
            dnl_next_o   = SAT_HI;
            out_of_range = 1'b1;
        end else if (diff < DIFF_LO) begin
            dnl_next_o   = SAT_LO;
            out_of_range = 1'b1;
        end else begin
            dnl_next_o   = diff[DNL_W-1:0];
        end
    end

    // Register the per-code value and the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dnl_q_o  <= '0;
            ovf_q_o  <= 1'b0;
            miss_q_o <= 1'b0;
        end else if (upd_i) begin
            dnl_q_o  <= dnl_next_o;
            ovf_q_o  <= ovf_q_o | out_of_range;
            miss_q_o <= miss_q_o | (cnt_i == '0);
        end
    end
endmodule

// File: rtl/lin_inl_stage.sv
// Running INL stage: adds each clamped per-code DNL into a signed sum one bit
// wider than the INL field, clamps the sum into the field and keeps a sticky
// overflow flag. Assumes INL_W > DNL_W.
module lin_inl_stage #(
    parameter int DNL_W = 4,
    parameter int INL_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_i,
    input  logic signed [DNL_W-1:0] dnl_i,
    output logic signed [INL_W-1:0] inl_next_o,
    output logic signed [INL_W-1:0] inl_q_o,
    output logic                    ovf_q_o
);
    localparam int SUM_W = INL_W + 1;
    localparam logic signed [SUM_W-1:0] SUM_HI = SUM_W'(2**(INL_W-1) - 1);
    localparam logic signed [SUM_W-1:0] SUM_LO = -SUM_W'(2**(INL_W-1));
    localparam logic signed [INL_W-1:0] SAT_HI = INL_W'(2**(INL_W-1) - 1);
    localparam logic signed [INL_W-1:0] SAT_LO = {1'b1, {(INL_W-1){1'b0}}};

    logic signed [SUM_W-1:0] sum;
    logic                    out_of_range;

    // Sign-extended add, then clamp to the field limits.
    always_comb begin
        sum = $signed({inl_q_o[INL_W-1], inl_q_o})
            + $signed({{(SUM_W-DNL_W){dnl_i[DNL_W-1]}}, dnl_i});
        out_of_range = 1'b0;
        if (sum > SUM_HI) begin
            inl_next_o   = SAT_HI;
            out_of_range = 1'b1;
        end else if (sum < SUM_LO) begin
            inl_next_o   = SAT_LO;
            out_of_range = 1'b1;
        end else begin
            inl_next_o   = sum[INL_W-1:0];
        end
    end

    // Register the running sum and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inl_q_o <= '0;
            ovf_q_o <= 1'b0;
        end else if (upd_i) begin
            inl_q_o <= inl_next_o;
            ovf_q_o <= ovf_q_o | out_of_range;
        end
    end
endmodule

// File: rtl/lin_peak.sv
// Peak-magnitude tracker: takes the magnitude of a signed value that is
// about to be registered and keeps the largest one seen. Assumes the most
// negative value's magnitude fits the unsigned W-bit result (it does:
// 2**(W-1) < 2**W).
module lin_peak #(
    parameter int W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_i,
    input  logic signed [W-1:0] val_i,
    output logic        [W-1:0] peak_o
);
    logic [W-1:0] mag;

    // Two's complement magnitude.
    always_comb mag = val_i[W-1] ? (~val_i + W'(1)) : val_i;

    // Replace the stored peak only on a strictly larger magnitude.
    always_ff @(posedge clk) begin
        if (!rst_n)                     peak_o <= '0;
        else if (upd_i && mag > peak_o) peak_o <= mag;
    end
endmodule

// File: rtl/linearity_accum.sv
// Top: streaming linearity accumulator. Connects the DNL stage, the INL
// stage, two peak trackers and the verdict logic. Assumes one count per
// strobe and a synchronous active-low reset to start each test.
module linearity_accum #(
    parameter int CNT_W = 5,
    parameter int DNL_W = 4,
    parameter int INL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_valid_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] ideal_i,
    input  logic [DNL_W-1:0] dnl_thr_i,
    input  logic [INL_W-1:0] inl_thr_i,
    output logic [DNL_W-1:0] dnl_o,
    output logic [INL_W-1:0] inl_o,
    output logic [DNL_W-1:0] dnl_peak_o,
    output logic [INL_W-1:0] inl_peak_o,
    output logic             dnl_ovf_o,
    output logic             inl_ovf_o,
    output logic             missing_o,
    output logic             fail_o,
    output logic             pass_o
);
    import lin_pkg::*;

    logic signed [DNL_W-1:0] dnl_next, dnl_q;
    logic signed [INL_W-1:0] inl_next, inl_q;
    lin_flags_t              flags;

    lin_dnl_stage #(.CNT_W(CNT_W), .DNL_W(DNL_W)) u_dnl (
        .clk(clk), .rst_n(rst_n), .upd_i(cnt_valid_i),
        .cnt_i(cnt_i), .ideal_i(ideal_i),
        .dnl_next_o(dnl_next), .dnl_q_o(dnl_q),
        .ovf_q_o(flags.dnl_ovf), .miss_q_o(flags.missing)
    );

    lin_inl_stage #(.DNL_W(DNL_W), .INL_W(INL_W)) u_inl (
        .clk(clk), .rst_n(rst_n), .upd_i(cnt_valid_i),
        .dnl_i(dnl_next), .inl_next_o(inl_next), .inl_q_o(inl_q),
        .ovf_q_o(flags.inl_ovf)
    );

    lin_peak #(.W(DNL_W)) u_dnl_peak (
        .clk(clk), .rst_n(rst_n), .upd_i(cnt_valid_i),
        .val_i(dnl_next), .peak_o(dnl_peak_o)
    );

    lin_peak #(.W(INL_W)) u_inl_peak (
        .clk(clk), .rst_n(rst_n), .upd_i(cnt_valid_i),
        .val_i(inl_next), .peak_o(inl_peak_o)
    );

    // Verdict: either overflow or a peak above its threshold fails.
    always_comb begin
        fail_o = flags.dnl_ovf | flags.inl_ovf
               | (dnl_peak_o > dnl_thr_i) | (inl_peak_o > inl_thr_i);
        pass_o = ~fail_o;
    end

    // Drive the per-code and flag outputs.
    always_comb begin
        dnl_o     = dnl_q;
        inl_o     = inl_q;
        dnl_ovf_o = flags.dnl_ovf;
        inl_ovf_o = flags.inl_ovf;
        missing_o = flags.missing;
    end
endmodule

// File: rtl/linearity_accum_chk.sv
// Checker for linearity_accum: temporal properties on the ports, bound to
// every instance of the top.
module linearity_accum_chk #(
    parameter int CNT_W = 5,
    parameter int DNL_W = 4,
    parameter int INL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_valid_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [DNL_W-1:0] dnl_thr_i,
    input logic [INL_W-1:0] inl_thr_i,
    input logic [DNL_W-1:0] dnl_o,
    input logic [INL_W-1:0] inl_o,
    input logic [DNL_W-1:0] dnl_peak_o,
    input logic [INL_W-1:0] inl_peak_o,
    input logic             dnl_ovf_o,
    input logic             inl_ovf_o,
    input logic             missing_o,
    input logic             fail_o,
    input logic             pass_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (dnl_o == '0 && inl_o == '0 && dnl_peak_o == '0 &&
                    inl_peak_o == '0 && !dnl_ovf_o && !inl_ovf_o && !missing_o));

    p_dnl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_valid_i |=> $stable(dnl_o));

    p_dnl_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dnl_ovf_o |=> dnl_ovf_o);

    p_inl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_valid_i |=> $stable(inl_o));

    p_inl_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inl_ovf_o |=> inl_ovf_o);

    p_dnl_peak_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> dnl_peak_o >= $past(dnl_peak_o));

    p_inl_peak_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> inl_peak_o >= $past(inl_peak_o));

    p_missing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid_i && cnt_i == '0) |=> missing_o);

    p_thr_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dnl_peak_o > dnl_thr_i || inl_peak_o > inl_thr_i) |-> (fail_o && !pass_o));

    p_ovf_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dnl_ovf_o || inl_ovf_o) |-> fail_o);
endmodule

bind linearity_accum linearity_accum_chk #(
    .CNT_W(CNT_W), .DNL_W(DNL_W), .INL_W(INL_W)
) chk_i (.*);

// File: tb/linearity_accum_tb_top.sv
// Bench: behavioural integer reference model compared on every clock.
module linearity_accum_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_valid_i = 1'b0;
    logic [4:0] cnt_i = '0;
    logic [4:0] ideal_i = 5'd8;
    logic [3:0] dnl_thr_i = 4'd4;
    logic [5:0] inl_thr_i = 6'd8;
    logic [3:0] dnl_o, dnl_peak_o;
    logic [5:0] inl_o, inl_peak_o;
    logic       dnl_ovf_o, inl_ovf_o, missing_o, fail_o, pass_o;

    int checks = 0, failures = 0;
    bit finished = 0;
    int m_dnl = 0, m_inl = 0, m_pd = 0, m_pi = 0;
    bit m_dovf = 0, m_iovf = 0, m_miss = 0;

    always #4 clk = ~clk;

    linearity_accum dut_i (.*);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input bit in_reset);
        bit exp_fail;
        string ft;
        exp_fail = m_dovf || m_iovf || (m_pd > int'(dnl_thr_i)) || (m_pi > int'(inl_thr_i));
        ft = in_reset ? "R1" : ((m_dovf || m_iovf) ? "R10" : "R9");
        check(in_reset ? "R1 dnl" : "R2 dnl", int'($signed(dnl_o)), m_dnl);
        check(in_reset ? "R1 dovf" : "R3 dovf", int'(dnl_ovf_o), int'(m_dovf));
        check(in_reset ? "R1 inl" : "R4 inl", int'($signed(inl_o)), m_inl);
        check(in_reset ? "R1 iovf" : "R5 iovf", int'(inl_ovf_o), int'(m_iovf));
        check(in_reset ? "R1 dpeak" : "R6 dpeak", int'(dnl_peak_o), m_pd);
        check(in_reset ? "R1 ipeak" : "R7 ipeak", int'(inl_peak_o), m_pi);
        check(in_reset ? "R1 miss" : "R8 miss", int'(missing_o), int'(m_miss));
        check({ft, " fail"}, int'(fail_o), int'(exp_fail));
        check({ft, " pass"}, int'(pass_o), int'(!exp_fail));
    endtask

    // One clock: drive, update the model at the edge, compare mid-cycle.
    task automatic cyc(input bit v, input int c);
        int d, s;
        cnt_valid_i = v;
        cnt_i = 5'(c);
        @(posedge clk);
        if (!rst_n) begin
            m_dnl = 0; m_inl = 0; m_pd = 0; m_pi = 0;
            m_dovf = 0; m_iovf = 0; m_miss = 0;
        end else if (v) begin
            d = c - int'(ideal_i);
            if (d > 7)  begin d = 7;  m_dovf = 1; end
            if (d < -8) begin d = -8; m_dovf = 1; end
            s = m_inl + d;
            if (s > 31)  begin s = 31;  m_iovf = 1; end
            if (s < -32) begin s = -32; m_iovf = 1; end
            m_dnl = d;
            m_inl = s;
            if ((d < 0 ? -d : d) > m_pd) m_pd = (d < 0 ? -d : d);
            if ((s < 0 ? -s : s) > m_pi) m_pi = (s < 0 ? -s : s);
            if (c == 0) m_miss = 1;
        end
        @(negedge clk);
        compare_all(!rst_n);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(0, 0);
        cyc(0, 0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset();                                   // R1
        for (int i = 0; i < 6; i++) cyc(1, 8);        // ideal codes, pass
        cyc(1, 10); cyc(0, 0); cyc(0, 0);             // R2 hold with no strobe
        cyc(1, 12);                                   // DNL peak 4 == threshold
        cyc(1, 5); cyc(1, 7);
        cyc(1, 13);                                   // DNL peak 5 > 4: R9 fail
        do_reset();
        cyc(1, 0);                                    // R8 missing, DNL -8 no ovf
        cyc(1, 20);                                   // R3 overflow +12 -> +7
        cyc(1, 8); cyc(0, 0);
        do_reset();
        for (int i = 0; i < 6; i++) cyc(1, 15);       // R5 INL beyond +31
        cyc(1, 1);
        do_reset();
        for (int i = 0; i < 9; i++) cyc(1, 4);        // INL reaches -32, then beyond
        do_reset();
        ideal_i = 5'd6; dnl_thr_i = 4'd2; inl_thr_i = 6'd3;
        for (int i = 0; i < 20; i++) cyc(i % 3 != 2, 4 + (i % 5));
        inl_thr_i = 6'd20;                            // threshold raised: R9 again
        cyc(0, 0);
        for (int i = 0; i < 10; i++) cyc(1, 6 + (i % 2));
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end
endmodule